// File: doc/BRIEF.md
# Multiplexed Cartridge Bus Master

This block runs single-byte read and write cycles against a cartridge whose 22-bit address space is reached through a narrow, time-shared connector. The upper address bits have dedicated output lines. The low address byte and the data byte share one 8-bit bidirectional bus. An external transparent latch, opened by a latch-enable strobe, keeps the low byte once the bus turns over to data. The memory target is chosen through two active-low inputs of an external NAND gate. With both inputs high, the mask ROM answers. Pulling the first input low enables the battery SRAM, and pulling the second low enables the CPU-internal RAM/IO window. Either one disables the ROM.

A host issues one request at a time on a valid/ready port carrying address, write data, a write flag and a 2-bit target code. The block latches the address, runs the target's strobe sequence with pulse widths and waits counted in clock cycles, and returns a one-clock acknowledge, with read data valid on that same clock. Every width is a parameter, so the same block fits any system clock. The defaults assume 50 MHz, which gives a 5 µs data wait for ROM reads.

Top module: `mux_cart_master`

## Requirements
- R1: After reset and between transactions, `req_ready` is 1, `rsp_ack` is 0, `le` is 0, `ad_oe` is 0, and `sel_a_n`, `sel_b_n`, `oe_n`, `we_n` are all 1.
- R2: For every transaction that reaches the cartridge, `cart_addr_hi` carries `req_addr[21:8]` and holds it steady until the acknowledge. The byte that the external latch holds when the data strobe falls equals `req_addr[7:0]`.
- R3: The latch phase drives `ad_out` with `ad_oe` = 1 and holds `le` high for `T_LATCH` cycles. `le` then stays low with the address still driven for `T_HOLD` cycles before `oe_n` or `we_n` falls.
- R4: A read holds `oe_n` low with `ad_oe` = 0 for `T_ROM_WAIT` cycles (ROM target) or `T_RAM_WAIT` cycles (SRAM or internal RAM/IO). The bus byte present in the last of those cycles is returned on `rsp_rdata` while `rsp_ack` is 1. `oe_n` and `we_n` are never low together, and `ad_oe` is never 1 while `oe_n` is low.
- R5: Target code `req_tgt` 0 selects ROM and leaves both selects high. Code 1 selects SRAM with `sel_a_n` low. Code 2 selects internal RAM/IO with `sel_b_n` low. Code 3 behaves as ROM. The chosen select stays low from the latch phase to the end of the strobe, and `sel_a_n` and `sel_b_n` are never low together.
- R6: An SRAM write holds `we_n` low for `T_SRAM_WE` cycles, with `ad_oe` = 1 and `ad_out` = `req_wdata` throughout.
- R7: An internal RAM/IO write first drives `sel_a_n` low for `T_PRE` cycles with `le` low and `sel_b_n` high. It then runs the latch phase with `sel_b_n` low, and holds `we_n` low for `T_IRAM_WE` cycles while driving `req_wdata`.
- R8: A write to target code 0 or 3 produces no latch, select or strobe activity and is acknowledged on the clock right after acceptance.
- R9: A request is taken only when `req_valid` and `req_ready` are both 1. `rsp_ack` rises exactly `T_LATCH+T_HOLD+W` clocks after the accepting edge, where W is the strobe width and `T_PRE` is added for internal RAM/IO writes, and it lasts one clock. `req_ready` is 0 from acceptance through the acknowledge, and requests raised in that window start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tgt | input | 2 | Target code: 0 ROM, 1 SRAM, 2 internal RAM/IO, 3 ROM |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_ack | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Read data, valid while rsp_ack is 1 |
| cart_addr_hi | output | 14 | Address bits 21..8 |
| ad_out | output | 8 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |
| le | output | 1 | Address latch enable, active high |
| sel_a_n | output | 1 | First NAND input (SRAM select), active low |
| sel_b_n | output | 1 | Second NAND input (RAM/IO select), active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach is the bus turnaround. The byte returned must come from the cartridge side after the latch has closed and the block has released the bus, not from the address still being driven. The bench models the transparent latch and the target memories itself. Its read value is a function of the select pins and the latched byte, so any mistake in latch timing, target decode or sampling cycle changes the returned data. A sweep over every target, direction and a set of addresses measures each strobe's width and the latency cycle by cycle. One run also holds `req_valid` high for the whole busy window to show that no second cycle follows.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

   typedef enum logic [1:0] {
      TGT_ROM     = 2'd0,
      TGT_SRAM    = 2'd1,
      TGT_IRAM    = 2'd2,
      TGT_ROM_ALT = 2'd3
   } mcb_tgt_e;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_PRE   = 3'd1,
      PH_ADDR  = 3'd2,
      PH_HOLD  = 3'd3,
      PH_READ  = 3'd4,
      PH_WRITE = 3'd5,
      PH_DONE  = 3'd6
   } mcb_phase_e;

   typedef struct packed {
      logic le;
      logic ad_oe;
      logic sel_a_n;
      logic sel_b_n;
      logic oe_n;
      logic we_n;
   } mcb_pins_t;

   localparam mcb_pins_t PINS_IDLE = '{le: 1'b0, ad_oe: 1'b0, sel_a_n: 1'b1,
                                       sel_b_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

   function automatic logic tgt_is_rom(mcb_tgt_e t);
      return (t == TGT_ROM) || (t == TGT_ROM_ALT);
   endfunction

   function automatic int unsigned max2(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Pin levels for one phase of the cycle and one target
   function automatic mcb_pins_t pins_for(mcb_phase_e ph, mcb_tgt_e t);
      mcb_pins_t p;
      logic      active;
      p       = PINS_IDLE;
      active  = (ph == PH_ADDR) || (ph == PH_HOLD) ||
                (ph == PH_READ) || (ph == PH_WRITE);
      p.le    = (ph == PH_ADDR);
      p.ad_oe = (ph == PH_ADDR) || (ph == PH_HOLD) || (ph == PH_WRITE);
      p.oe_n  = !(ph == PH_READ);
      p.we_n  = !(ph == PH_WRITE);
      p.sel_a_n = !((ph == PH_PRE) || (active && t == TGT_SRAM));
      p.sel_b_n = !(active && t == TGT_IRAM);
      return p;
   endfunction

endpackage

// File: rtl/mcb_phase_timer.sv
module mcb_phase_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/mcb_sequencer.sv
module mcb_sequencer
   import mcb_pkg::*;
#(
   parameter int unsigned T_PRE      = 2,
   parameter int unsigned T_LATCH    = 2,
   parameter int unsigned T_HOLD     = 2,
   parameter int unsigned T_ROM_WAIT = 250,
   parameter int unsigned T_RAM_WAIT = 4,
   parameter int unsigned T_SRAM_WE  = 12,
   parameter int unsigned T_IRAM_WE  = 37,
   parameter int unsigned CW         = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       wr,
   input  mcb_tgt_e   tgt,
   output mcb_phase_e ph,
   output mcb_phase_e ph_nxt,
   output logic       sample
);

   localparam logic [CW-1:0] D_PRE   = CW'(T_PRE - 1);
   localparam logic [CW-1:0] D_LATCH = CW'(T_LATCH - 1);
   localparam logic [CW-1:0] D_HOLD  = CW'(T_HOLD - 1);
   localparam logic [CW-1:0] D_ROMRD = CW'(T_ROM_WAIT - 1);
   localparam logic [CW-1:0] D_RAMRD = CW'(T_RAM_WAIT - 1);
   localparam logic [CW-1:0] D_SWE   = CW'(T_SRAM_WE - 1);
   localparam logic [CW-1:0] D_IWE   = CW'(T_IRAM_WE - 1);

   mcb_phase_e    ph_q;
   logic          expired;
   logic          load;
   logic [CW-1:0] dur;

   always_comb begin
      ph_nxt = ph_q;
      unique case (ph_q)
         PH_IDLE:  if (start) begin
                      if (wr && tgt_is_rom(tgt))      ph_nxt = PH_DONE;
                      else if (wr && tgt == TGT_IRAM) ph_nxt = PH_PRE;
                      else                            ph_nxt = PH_ADDR;
                   end
         PH_PRE:   if (expired) ph_nxt = PH_ADDR;
         PH_ADDR:  if (expired) ph_nxt = PH_HOLD;
         PH_HOLD:  if (expired) ph_nxt = wr ? PH_WRITE : PH_READ;
         PH_READ:  if (expired) ph_nxt = PH_DONE;
         PH_WRITE: if (expired) ph_nxt = PH_DONE;
         default:  ph_nxt = PH_IDLE;
      endcase
   end

   always_comb begin
      unique case (ph_nxt)
         PH_PRE:   dur = D_PRE;
         PH_ADDR:  dur = D_LATCH;
         PH_HOLD:  dur = D_HOLD;
         PH_READ:  dur = tgt_is_rom(tgt) ? D_ROMRD : D_RAMRD;
         PH_WRITE: dur = (tgt == TGT_SRAM) ? D_SWE : D_IWE;
         default:  dur = '0;
      endcase
   end

   assign load = (ph_nxt != ph_q);

   mcb_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (dur),
      .expired  (expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_nxt;
   end

   assign ph     = ph_q;
   assign sample = (ph_q == PH_READ) && expired;

endmodule

// File: rtl/mcb_pin_drive.sv
module mcb_pin_drive
   import mcb_pkg::*;
#(
   parameter bit          PIN_REG = 1'b1,
   parameter int unsigned DW      = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  mcb_phase_e    ph,
   input  mcb_phase_e    ph_nxt,
   input  mcb_tgt_e      tgt,
   input  logic [DW-1:0] addr_lo,
   input  logic [DW-1:0] wdata,
   output mcb_pins_t     pins,
   output logic [DW-1:0] bus_val
);

   generate
      if (PIN_REG) begin : g_registered
         // Pins come straight from flops, decoded one phase ahead
         mcb_pins_t     pins_q;
         logic [DW-1:0] bus_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pins_q <= PINS_IDLE;
               bus_q  <= '0;
            end else begin
               pins_q <= pins_for(ph_nxt, tgt);
               bus_q  <= (ph_nxt == PH_WRITE) ? wdata : addr_lo;
            end
         end
         assign pins    = pins_q;
         assign bus_val = bus_q;
      end else begin : g_decoded
         // Pins decoded from the current phase register
         assign pins    = pins_for(ph, tgt);
         assign bus_val = (ph == PH_WRITE) ? wdata : addr_lo;
      end
   endgenerate

endmodule

// File: rtl/mux_cart_master.sv
module mux_cart_master
   import mcb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 22,
   parameter int unsigned DW         = 8,
   parameter bit          PIN_REG    = 1'b1,
   parameter int unsigned T_PRE      = 2,
   parameter int unsigned T_LATCH    = 2,
   parameter int unsigned T_HOLD     = 2,
   parameter int unsigned T_ROM_WAIT = 250,
   parameter int unsigned T_RAM_WAIT = 4,
   parameter int unsigned T_SRAM_WE  = 12,
   parameter int unsigned T_IRAM_WE  = 37
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [1:0]           req_tgt,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DW-1:0]        req_wdata,
   output logic                 rsp_ack,
   output logic [DW-1:0]        rsp_rdata,
   output logic [ADDR_W-DW-1:0] cart_addr_hi,
   output logic [DW-1:0]        ad_out,
   output logic                 ad_oe,
   input  logic [DW-1:0]        ad_in,
   output logic                 le,
   output logic                 sel_a_n,
   output logic                 sel_b_n,
   output logic                 oe_n,
   output logic                 we_n
);

   localparam int unsigned T_MAX = max2(max2(max2(T_PRE, T_LATCH), max2(T_HOLD, T_ROM_WAIT)),
                                        max2(T_RAM_WAIT, max2(T_SRAM_WE, T_IRAM_WE)));
   localparam int unsigned CW    = (T_MAX > 2) ? $clog2(T_MAX) : 1;

   initial begin
      assert (ADDR_W > DW) else $error("ADDR_W must exceed DW");
      assert (T_PRE >= 1 && T_LATCH >= 1 && T_HOLD >= 1)
         else $error("latch phase widths must be at least one cycle");
      assert (T_ROM_WAIT >= 1 && T_RAM_WAIT >= 1 && T_SRAM_WE >= 1 && T_IRAM_WE >= 1)
         else $error("strobe widths must be at least one cycle");
   end

   mcb_phase_e          ph, ph_nxt;
   logic                sample;
   logic                accept;
   logic [ADDR_W-1:0]   addr_q;
   logic [DW-1:0]       wdata_q;
   logic                wr_q;
   mcb_tgt_e            tgt_q;
   logic [DW-1:0]       rdata_q;
   mcb_tgt_e            tgt_cur;
   logic                wr_cur;
   logic [ADDR_W-1:0]   addr_cur;
   logic [DW-1:0]       wdata_cur;
   mcb_pins_t           pins;

   assign req_ready = (ph == PH_IDLE);
   assign accept    = req_valid && req_ready;

   // Request fields as seen by the decode: live on the accepting edge
   assign tgt_cur   = accept ? mcb_tgt_e'(req_tgt) : tgt_q;
   assign wr_cur    = accept ? req_write : wr_q;
   assign addr_cur  = accept ? req_addr  : addr_q;
   assign wdata_cur = accept ? req_wdata : wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         wr_q    <= 1'b0;
         tgt_q   <= TGT_ROM;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         wr_q    <= req_write;
         tgt_q   <= mcb_tgt_e'(req_tgt);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (sample) rdata_q <= ad_in;
   end

   mcb_sequencer #(
      .T_PRE      (T_PRE),
      .T_LATCH    (T_LATCH),
      .T_HOLD     (T_HOLD),
      .T_ROM_WAIT (T_ROM_WAIT),
      .T_RAM_WAIT (T_RAM_WAIT),
      .T_SRAM_WE  (T_SRAM_WE),
      .T_IRAM_WE  (T_IRAM_WE),
      .CW         (CW)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (accept),
      .wr     (wr_cur),
      .tgt    (tgt_cur),
      .ph     (ph),
      .ph_nxt (ph_nxt),
      .sample (sample)
   );

   mcb_pin_drive #(
      .PIN_REG (PIN_REG),
      .DW      (DW)
   ) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .ph      (ph),
      .ph_nxt  (ph_nxt),
      .tgt     (tgt_cur),
      .addr_lo (addr_cur[DW-1:0]),
      .wdata   (wdata_cur),
      .pins    (pins),
      .bus_val (ad_out)
   );

   assign le           = pins.le;
   assign ad_oe        = pins.ad_oe;
   assign sel_a_n      = pins.sel_a_n;
   assign sel_b_n      = pins.sel_b_n;
   assign oe_n         = pins.oe_n;
   assign we_n         = pins.we_n;
   assign rsp_ack      = (ph == PH_DONE);
   assign rsp_rdata    = rdata_q;
   assign cart_addr_hi = addr_q[ADDR_W-1:DW];

endmodule

// File: rtl/mux_cart_master_props.sv
module mux_cart_master_props #(
   parameter int unsigned ADDR_W = 22,
   parameter int unsigned DW     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic                 rsp_ack,
   input logic [ADDR_W-DW-1:0] cart_addr_hi,
   input logic [DW-1:0]        ad_out,
   input logic                 ad_oe,
   input logic                 le,
   input logic                 sel_a_n,
   input logic                 sel_b_n,
   input logic                 oe_n,
   input logic                 we_n
);

   a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!le && !ad_oe && sel_a_n && sel_b_n && oe_n && we_n));

   a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> $stable(cart_addr_hi));

   a_r3_latch_closed_before_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_n) |-> (!le && $past(!le)));

   a_r3_latch_closed_before_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> (!le && $past(!le)));

   a_r4_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !ad_oe);

   a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));

   a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sel_a_n && !sel_b_n));

   a_r6_write_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_n && $past(!we_n)) |-> (ad_oe && $stable(ad_out)));

   a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ack |=> (!rsp_ack && req_ready));

   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

endmodule

bind mux_cart_master mux_cart_master_props #(.ADDR_W(ADDR_W), .DW(DW)) u_props (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .rsp_ack      (rsp_ack),
   .cart_addr_hi (cart_addr_hi),
   .ad_out       (ad_out),
   .ad_oe        (ad_oe),
   .le           (le),
   .sel_a_n      (sel_a_n),
   .sel_b_n      (sel_b_n),
   .oe_n         (oe_n),
   .we_n         (we_n)
);

// File: tb/mux_cart_master_test.sv
module mux_cart_master_test;

   localparam int P_PRE = 2, P_LATCH = 2, P_HOLD = 1;
   localparam int P_ROMW = 7, P_RAMW = 3, P_SWE = 4, P_IWE = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [1:0]  req_tgt = 2'd0;
   logic [21:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        rsp_ack;
   logic [7:0]  rsp_rdata;
   logic [13:0] cart_addr_hi;
   logic [7:0]  ad_out;
   logic        ad_oe;
   logic [7:0]  ad_in;
   logic        le, sel_a_n, sel_b_n, oe_n, we_n;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;
   logic [7:0] lat = 8'h00;

   always #5 clk = ~clk;

   function automatic logic [7:0] mdl(input logic [1:0] t, input logic [21:0] a);
      return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ {t, 6'h15};
   endfunction

   // Cartridge side: transparent latch and target memories
   always @(negedge clk) if (le && ad_oe) lat <= ad_out;
   wire [1:0] tsel = !sel_a_n ? 2'd1 : (!sel_b_n ? 2'd2 : 2'd0);
   assign ad_in = oe_n ? 8'h5A : mdl(tsel, {cart_addr_hi, lat});

   mux_cart_master #(
      .T_PRE(P_PRE), .T_LATCH(P_LATCH), .T_HOLD(P_HOLD), .T_ROM_WAIT(P_ROMW),
      .T_RAM_WAIT(P_RAMW), .T_SRAM_WE(P_SWE), .T_IRAM_WE(P_IWE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_tgt(req_tgt), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
      .cart_addr_hi(cart_addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .le(le), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .oe_n(oe_n), .we_n(we_n)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic run_txn(input logic wr, input logic [1:0] t, input logic [21:0] a,
                          input logic [7:0] d, input bit hammer);
      int lat_n = 0, le_n = 0, oe_cnt = 0, we_cnt = 0, sa_n = 0, sb_n = 0, hold_n = 0;
      int bad_wd = 0, bad_oe = 0, sa_le = 0, pre_done = 0;
      logic [7:0]  lat_at = 8'h00;
      logic [13:0] hi_at = '0;
      bit seen_strobe = 0, seen_le = 0;
      bit rom = (t == 2'd0) || (t == 2'd3);
      int w, exp_lat, exp_sa, exp_sb;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_tgt = t; req_addr = a; req_wdata = d;
      @(posedge clk);
      forever begin
         @(negedge clk);
         if (!hammer) req_valid = 1'b0;
         else req_addr = a ^ 22'h2AAAAA;
         if (rsp_ack) break;
         check(!req_ready, "R9 ready low while busy", req_ready, 0);
         lat_n++;
         if (le) begin le_n++; seen_le = 1; end
         if (!oe_n) oe_cnt++;
         if (!we_n) we_cnt++;
         if (!sel_a_n) begin sa_n++; if (le) sa_le++; end
         if (!sel_b_n) sb_n++;
         if (!oe_n && ad_oe) bad_oe++;
         if (!we_n && (!ad_oe || ad_out != d)) bad_wd++;
         if (seen_le && !le && ad_oe && oe_n && we_n) hold_n++;
         if (!sel_b_n && sa_n > 0 && !seen_le) pre_done++;
         if ((!oe_n || !we_n) && !seen_strobe) begin
            seen_strobe = 1; lat_at = lat; hi_at = cart_addr_hi;
         end
      end
      req_valid = 1'b0;
      if (wr && rom) begin
         check(lat_n == 0, "R8 rom write latency", lat_n, 0);
         check(le_n + sa_n + sb_n + oe_cnt + we_cnt == 0, "R8 rom write no activity",
               le_n + sa_n + sb_n + oe_cnt + we_cnt, 0);
         return;
      end
      w = wr ? ((t == 2'd1) ? P_SWE : P_IWE) : (rom ? P_ROMW : P_RAMW);
      exp_lat = P_LATCH + P_HOLD + w + ((wr && t == 2'd2) ? P_PRE : 0);
      check(lat_n == exp_lat, "R9 ack latency", lat_n, exp_lat);
      check(hi_at == a[21:8], "R2 high address", hi_at, a[21:8]);
      check(lat_at == a[7:0], "R2 latched low byte", lat_at, a[7:0]);
      check(le_n == P_LATCH, "R3 latch width", le_n, P_LATCH);
      check(hold_n == P_HOLD, "R3 hold after latch", hold_n, P_HOLD);
      exp_sa = (t == 2'd1) ? P_LATCH + P_HOLD + w : ((wr && t == 2'd2) ? P_PRE : 0);
      exp_sb = (t == 2'd2) ? P_LATCH + P_HOLD + w : 0;
      check(sa_n == exp_sa, "R5 sel_a_n low cycles", sa_n, exp_sa);
      check(sb_n == exp_sb, "R5 sel_b_n low cycles", sb_n, exp_sb);
      if (wr) begin
         check(we_cnt == w, (t == 2'd1) ? "R6 sram we width" : "R7 iram we width", we_cnt, w);
         check(bad_wd == 0, "R6 write data driven", bad_wd, 0);
         check(oe_cnt == 0, "R4 no oe on write", oe_cnt, 0);
         if (t == 2'd2) begin
            check(sa_le == 0, "R7 pre pulse before latch", sa_le, 0);
            check(pre_done == 0, "R7 selects not overlapping", pre_done, 0);
         end
      end else begin
         check(oe_cnt == w, "R4 oe width", oe_cnt, w);
         check(bad_oe == 0, "R4 bus released during oe", bad_oe, 0);
         check(we_cnt == 0, "R4 no we on read", we_cnt, 0);
         check(rsp_rdata == mdl(rom ? 2'd0 : t, a), "R4 read data",
               rsp_rdata, mdl(rom ? 2'd0 : t, a));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready && !rsp_ack && !le && !ad_oe && sel_a_n && sel_b_n && oe_n && we_n,
            "R1 reset state", {req_ready, rsp_ack, le, ad_oe, sel_a_n, sel_b_n, oe_n, we_n},
            8'b10001111);
      rst_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         for (int t = 0; t < 4; t++) begin
            for (int wr = 0; wr < 2; wr++) begin
               logic [21:0] a;
               a = (22'h3FFFFF >> (i * 4)) ^ 22'(i * 32'h12345);
               run_txn(wr[0], t[1:0], a, 8'(i * 37 + t * 11 + 3), 1'b0);
               @(negedge clk);
               check(req_ready && le == 0 && oe_n && we_n && sel_a_n && sel_b_n,
                     "R1 idle between transactions", req_ready, 1);
            end
         end
      end
      // Requests raised while busy must start nothing
      run_txn(1'b0, 2'd1, 22'h0ABCDE, 8'h00, 1'b1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(req_ready && !le && oe_n && !rsp_ack, "R9 busy request ignored",
               {req_ready, le, oe_n, rsp_ack}, 4'b1010);
      end
      finished = 1'b1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

endmodule